// File: doc/BRIEF.md
# I2C register-access slave

This block is a seven-bit-address I2C slave. It gives a front-end chip read and write access to its internal register file over a single-master two-wire bus. The block samples SCL and SDA with the system clock. Both lines pass through a two-flop synchroniser and a glitch filter before START, STOP and clock edges are detected. SDA is driven open-drain: when `sda_oe_o` is high, the pad pulls the line low. The block never drives SCL, so it never stretches the clock.

The slave address is made of a hardwired two-bit device-type code in bits [6:5] and a low field of five bits. How many low bits come from the address pins depends on the type:

- Types 00 and 01 take pins [2:0]; bits [4:3] come from a fixed parameter.
- Type 10 takes all five pins.
- Type 11 takes no pins.

The pins are latched at reset and again on a software reset.

A write transfer works through an index pointer. The first data byte after the address sets the index. Every later byte is written at the index, and the index then moves on. A read transfer returns data starting at the stored index, so a random read is an index write, a repeated START and a read address. Three read-only device-identifier bytes sit at a parameterised index. A general call followed by 06h performs a software reset.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte (seven address bits, then the direction bit, 0 = write, 1 = read) only when bits [7:6] of the byte equal DEV_TYPE. The low five address bits must equal the latched pins where the type's mask selects pins (type 10: all five; types 00/01: bits [2:0]), and FIXED_LOW elsewhere. Any other address is not acknowledged.
- R2: An address whose upper four bits are 0000 or 1111 is never acknowledged. This includes 0000000 with the read bit. The single exception is 0000000 with the write bit.
- R3: A START or repeated START seen at any point restarts byte reception, and the next byte is taken as an address. A partly received data byte is discarded without a register write.
- R4: In a write transfer, the first data byte loads the index (its low log2(REG_DEPTH) bits). Each later byte gives a one-cycle `reg_we_o` pulse with `reg_addr_o` = index and `reg_wdata_o` = byte, and the index then increments. Every byte is acknowledged.
- R5: After a read address is acknowledged, the slave sends the byte at the stored index, MSB first. The stored index is kept across a repeated START.
- R6: A master ACK after a read byte increments the index and sends the next byte. A master NACK makes the slave release SDA until the next START.
- R7: The general-call write address 0000000 is acknowledged. A second byte of 06h is acknowledged and then triggers a software reset, which clears the index to 0 and re-latches the address pins. Any other second byte is not acknowledged.
- R8: Indices ID_BASE, ID_BASE+1 and ID_BASE+2 read DEVICE_ID bits [23:16], [15:8] and [7:0]. A write to these indices produces no `reg_we_o` pulse, but the index still advances.
- R9: The index wraps modulo REG_DEPTH (a power of two) on both reads and writes.
- R10: `sda_oe_o` changes only while SCL is low, HOLD_CLKS system clocks after the filtered SCL falling edge.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.
- R12: During and right after reset, `sda_oe_o` and `reg_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe_o | output | 1 | Pull SDA low when high |
| addr_pins_i | input | 5 | Pin-strapped low address bits |
| reg_addr_o | output | log2(REG_DEPTH) | Register-file address (write address during a write pulse, index otherwise) |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Synchronous read data for `reg_addr_o`, one cycle later |

## Verification
Two functions can act on the same state at once. A START can arrive in the middle of a data byte, in the same stretch of cycles in which the bit counter is advancing towards the register write. The bench provokes this by issuing a repeated START after four data bits. It then checks three things: the new address is acknowledged, the scoreboard sees only the write from the following complete byte, and the register at the abandoned index reads back unchanged. A second overlap is the software reset, where the address re-latch and the index clear coincide with the end of the acknowledge. The bench judges it by the new pin address being accepted, the old one being refused, and a read with no index write returning index 0.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} slv_st_e;
  localparam logic [7:0] SRST_CMD = 8'h06;
  localparam int         ID_BYTES = 3;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3,
  localparam int CW = $clog2(FILT_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // level only follows after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != clean_o) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          clean_o <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, clean, prev_q;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .clean_o(clean[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= clean;
  end

  assign sda_o      = clean[1];
  assign scl_rise_o = clean[0] & ~prev_q[0];
  assign scl_fall_o = ~clean[0] & prev_q[0];
  assign start_o    = clean[0] & prev_q[0] & prev_q[1] & ~clean[1];
  assign stop_o     = clean[0] & prev_q[0] & ~prev_q[1] & clean[1];
endmodule

// File: rtl/i2c_sda_driver.sv
module i2c_sda_driver #(
  parameter int HOLD_CLKS = 4,
  localparam int CW = $clog2(HOLD_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_fall_i,
  input  logic drive_i,
  input  logic release_i,
  output logic oe_o
);
  logic [CW-1:0] cnt_q;
  logic          pend_q;

  // drive level is applied HOLD_CLKS after each SCL fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (release_i) begin
      oe_o   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (scl_fall_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (cnt_q == CW'(HOLD_CLKS - 1)) begin
        oe_o   <= drive_i;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter logic [1:0] DEV_TYPE  = 2'b10,
  parameter logic [4:0] FIXED_LOW = 5'b00000
) (
  input  logic [4:0] pins_i,
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output logic       gcall_o
);
  localparam logic [4:0] PIN_MASK = (DEV_TYPE == 2'b10) ? 5'h1F :
                                    (DEV_TYPE == 2'b11) ? 5'h00 : 5'h07;
  logic [6:0] own;
  logic       reserved;

  assign own      = {DEV_TYPE, (pins_i & PIN_MASK) | (FIXED_LOW & ~PIN_MASK)};
  assign reserved = (byte_i[7:4] == 4'b0000) || (byte_i[7:4] == 4'b1111);
  assign hit_o    = (byte_i[7:1] == own) && !reserved;
  assign gcall_o  = (byte_i == 8'h00);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [1:0]  DEV_TYPE  = 2'b10,
  parameter logic [4:0]  FIXED_LOW = 5'b00000,
  parameter int          REG_DEPTH = 32,
  parameter int          ID_BASE   = 29,
  parameter logic [23:0] DEVICE_ID = 24'hA5C317,
  parameter int          FILT_LEN  = 3,
  parameter int          HOLD_CLKS = 4,
  localparam int         IDX_W     = $clog2(REG_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [4:0]       addr_pins_i,
  output logic [IDX_W-1:0] reg_addr_o,
  output logic             reg_we_o,
  output logic [7:0]       reg_wdata_o,
  input  logic [7:0]       reg_rdata_i
);
  logic sda_f, scl_rise, scl_fall, start_det, stop_det;
  logic hit, gcall, drive_d;

  slv_st_e          st_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic [IDX_W-1:0] idx_q, waddr_q;
  logic [4:0]       pins_q;
  logic             pins_load_q, addr_ph_q, idx_ph_q, rd_mode_q, gc_mode_q;
  logic             srst_pend_q, ack_q, mack_q, we_q;
  logic [7:0]       wdata_q;
  logic [7:0]       rx_byte, tx_byte;

  function automatic logic id_hit(input logic [IDX_W-1:0] a);
    return (int'(a) >= ID_BASE) && (int'(a) < ID_BASE + ID_BYTES);
  endfunction

  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] a);
    case (int'(a) - ID_BASE)
      0:       return DEVICE_ID[23:16];
      1:       return DEVICE_ID[15:8];
      default: return DEVICE_ID[7:0];
    endcase
  endfunction

  i2c_bus_cond #(.FILT_LEN(FILT_LEN)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_addr_match #(.DEV_TYPE(DEV_TYPE), .FIXED_LOW(FIXED_LOW)) u_match (
    .pins_i (pins_q),
    .byte_i (rx_byte),
    .hit_o  (hit),
    .gcall_o(gcall)
  );

  i2c_sda_driver #(.HOLD_CLKS(HOLD_CLKS)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_fall_i(scl_fall),
    .drive_i   (drive_d),
    .release_i (start_det | stop_det),
    .oe_o      (sda_oe_o)
  );

  assign rx_byte = {sh_q[6:0], sda_f};
  assign tx_byte = id_hit(idx_q) ? id_byte(idx_q) : reg_rdata_i;
  assign drive_d = (st_q == ST_ACK) || ((st_q == ST_TX) && !sh_q[7]);

  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_addr_o  = we_q ? waddr_q : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      idx_q       <= '0;
      waddr_q     <= '0;
      wdata_q     <= '0;
      pins_q      <= '0;
      pins_load_q <= 1'b1;
      addr_ph_q   <= 1'b0;
      idx_ph_q    <= 1'b0;
      rd_mode_q   <= 1'b0;
      gc_mode_q   <= 1'b0;
      srst_pend_q <= 1'b0;
      ack_q       <= 1'b0;
      mack_q      <= 1'b0;
      we_q        <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (pins_load_q) begin
        pins_q      <= addr_pins_i;
        pins_load_q <= 1'b0;
      end
      if (start_det) begin
        st_q        <= ST_RX;
        bit_cnt_q   <= '0;
        addr_ph_q   <= 1'b1;
        gc_mode_q   <= 1'b0;
        srst_pend_q <= 1'b0;
        ack_q       <= 1'b0;
      end else if (stop_det) begin
        st_q        <= ST_IDLE;
        gc_mode_q   <= 1'b0;
        srst_pend_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              sh_q      <= rx_byte;
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == 4'd7) begin
                if (addr_ph_q) begin
                  addr_ph_q <= 1'b0;
                  if (hit) begin
                    ack_q     <= 1'b1;
                    rd_mode_q <= rx_byte[0];
                    idx_ph_q  <= !rx_byte[0];
                  end else if (gcall) begin
                    ack_q     <= 1'b1;
                    gc_mode_q <= 1'b1;
                    rd_mode_q <= 1'b0;
                    idx_ph_q  <= 1'b0;
                  end else begin
                    ack_q <= 1'b0;
                  end
                end else if (gc_mode_q) begin
                  ack_q       <= (rx_byte == SRST_CMD);
                  srst_pend_q <= (rx_byte == SRST_CMD);
                end else if (idx_ph_q) begin
                  idx_q    <= rx_byte[IDX_W-1:0];
                  idx_ph_q <= 1'b0;
                  ack_q    <= 1'b1;
                end else begin
                  ack_q   <= 1'b1;
                  we_q    <= !id_hit(idx_q);
                  waddr_q <= idx_q;
                  wdata_q <= rx_byte;
                  idx_q   <= idx_q + 1'b1;
                end
              end
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              st_q <= ack_q ? ST_ACK : ST_IDLE;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (srst_pend_q) begin
                st_q        <= ST_IDLE;
                idx_q       <= '0;
                pins_load_q <= 1'b1;
                srst_pend_q <= 1'b0;
                gc_mode_q   <= 1'b0;
              end else if (rd_mode_q) begin
                st_q <= ST_TX;
                sh_q <= tx_byte;
              end else begin
                st_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt_q == 4'd7) begin
                st_q <= ST_MACK;
              end else begin
                sh_q      <= {sh_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= !sda_f;
              if (!sda_f) idx_q <= idx_q + 1'b1;
            end else if (scl_fall) begin
              if (mack_q) begin
                st_q      <= ST_TX;
                sh_q      <= tx_byte;
                bit_cnt_q <= '0;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int IDX_W   = 5,
  parameter int ID_BASE = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             reg_we_o,
  input logic [IDX_W-1:0] reg_addr_o
);
  // R4
  we_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R8
  id_write_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (int'(reg_addr_o) < ID_BASE || int'(reg_addr_o) >= ID_BASE + 3));

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  // R10
  oe_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_i);

  // R12
  always @(posedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!sda_oe_o && !reg_we_o);
  end
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.IDX_W(IDX_W), .ID_BASE(ID_BASE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic [4:0] pins;
  logic       sda_oe, we;
  logic [4:0] raddr;
  logic [7:0] wdata, rdata;
  logic       sda_line;
  logic [7:0] mem [32];

  int n_chk = 0, n_err = 0, oe_bad = 0;
  bit done = 0;
  logic oe_prev = 1'b0;
  logic [15:0] exp_q [$];

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_reg_slave uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .addr_pins_i(pins),
    .reg_addr_o (raddr),
    .reg_we_o   (we),
    .reg_wdata_o(wdata),
    .reg_rdata_i(rdata)
  );

  // synchronous register file model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= 8'h00;
      rdata <= 8'h00;
    end else begin
      if (we) mem[raddr] <= wdata;
      rdata <= mem[raddr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for register writes (R4, R8)
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected register write", {19'b0, raddr, wdata}, 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk("R4 register write addr/data", {16'b0, 3'b0, raddr, wdata}, {16'b0, e});
      end
    end
    if (m_scl && sda_oe !== oe_prev) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic bit_x(input logic b, input bit glitch, output logic s);
    m_sda = b;
    repeat (Q) @(negedge clk);
    m_scl = 1'b1;
    repeat (3) @(negedge clk);
    if (glitch) begin
      m_scl = 1'b0;
      @(negedge clk);
      m_scl = 1'b1;
    end else begin
      @(negedge clk);
    end
    repeat (Q - 4) @(negedge clk);
    s = sda_line;
    repeat (Q) @(negedge clk);
    m_scl = 1'b0;
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    if (m_scl == 1'b0) begin
      m_sda = 1'b1;
      repeat (Q) @(negedge clk);
      m_scl = 1'b1;
      repeat (Q) @(negedge clk);
    end
    m_sda = 1'b0;
    repeat (Q) @(negedge clk);
    m_scl = 1'b0;
    repeat (Q) @(negedge clk);
  endtask

  task automatic stop_c();
    m_sda = 1'b0;
    repeat (Q) @(negedge clk);
    m_scl = 1'b1;
    repeat (Q) @(negedge clk);
    m_sda = 1'b1;
    repeat (Q) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], glitch, s);
    bit_x(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, 1'b0, s);
      d[i] = s;
    end
    bit_x(!mack, 1'b0, s);
  endtask

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    logic s;
    int rel_bad;
    logic [7:0] rsv [5];
    rsv = '{8'h01, 8'h02, 8'h0F, 8'hFE, 8'hF0};

    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; pins = 5'h05;
    repeat (5) @(negedge clk);
    chk("R12 sda_oe in reset", sda_oe, 0);
    chk("R12 reg_we in reset", we, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 sda_oe after reset", sda_oe, 0);

    // R1/R4: sequential write from index 3 to own address 0x45
    start_c(); wr_byte(8'h8A, 0, a); chk("R1 own address ack", a, 1);
    wr_byte(8'h03, 0, a); chk("R4 index byte ack", a, 1);
    push_wr(8'h03, 8'h11); wr_byte(8'h11, 0, a); chk("R4 data ack", a, 1);
    push_wr(8'h04, 8'h22); wr_byte(8'h22, 0, a);
    push_wr(8'h05, 8'h33); wr_byte(8'h33, 0, a);
    stop_c();

    // R5/R6: random sequential read
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h03, 0, a);
    start_c(); wr_byte(8'h8B, 0, a); chk("R5 read address ack", a, 1);
    rd_byte(1, d); chk("R5 first byte at stored index", d, 8'h11);
    rd_byte(1, d); chk("R6 ack advances index", d, 8'h22);
    rd_byte(0, d); chk("R6 ack advances index again", d, 8'h33);
    rel_bad = 0;
    for (int i = 0; i < 9; i++) begin
      bit_x(1'b1, 1'b0, s);
      if (s !== 1'b1) rel_bad++;
    end
    chk("R6 SDA released after NACK", rel_bad, 0);
    stop_c();

    // R1: foreign address
    start_c(); wr_byte(8'h8C, 0, a); chk("R1 foreign address nack", a, 0); stop_c();

    // R2: reserved addresses
    for (int i = 0; i < 5; i++) begin
      start_c(); wr_byte(rsv[i], 0, a); chk("R2 reserved address nack", a, 0); stop_c();
    end

    // R8/R9: write wraps past ID bytes
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h1F, 0, a);
    wr_byte(8'h5A, 0, a); chk("R8 write to ID still acked", a, 1);
    push_wr(8'h00, 8'h6B); wr_byte(8'h6B, 0, a);
    stop_c();
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h1D, 0, a);
    start_c(); wr_byte(8'h8B, 0, a);
    rd_byte(1, d); chk("R8 id byte 0", d, 8'hA5);
    rd_byte(1, d); chk("R8 id byte 1", d, 8'hC3);
    rd_byte(1, d); chk("R8 id byte 2", d, 8'h17);
    rd_byte(0, d); chk("R9 read wraps to index 0", d, 8'h6B);
    stop_c();

    // R8: write to ID has no effect
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h1E, 0, a); wr_byte(8'hFF, 0, a); stop_c();
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h1E, 0, a);
    start_c(); wr_byte(8'h8B, 0, a);
    rd_byte(0, d); chk("R8 id byte unchanged after write", d, 8'hC3);
    stop_c();

    // R3: repeated START after four data bits
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h08, 0, a);
    bit_x(1'b1, 0, s); bit_x(1'b0, 0, s); bit_x(1'b1, 0, s); bit_x(1'b0, 0, s);
    start_c(); wr_byte(8'h8A, 0, a); chk("R3 address after misplaced START", a, 1);
    wr_byte(8'h09, 0, a);
    push_wr(8'h09, 8'h77); wr_byte(8'h77, 0, a);
    stop_c();
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h08, 0, a);
    start_c(); wr_byte(8'h8B, 0, a);
    rd_byte(1, d); chk("R3 abandoned byte not written", d, 8'h00);
    rd_byte(0, d); chk("R3 following write landed", d, 8'h77);
    stop_c();

    // R11: short SCL glitches during a write
    start_c(); wr_byte(8'h8A, 1, a); chk("R11 ack with glitches", a, 1);
    wr_byte(8'h0C, 1, a);
    push_wr(8'h0C, 8'h3C); wr_byte(8'h3C, 1, a);
    stop_c();
    start_c(); wr_byte(8'h8A, 0, a); wr_byte(8'h0C, 0, a);
    start_c(); wr_byte(8'h8B, 0, a);
    rd_byte(0, d); chk("R11 glitched write data", d, 8'h3C);
    stop_c();

    // R7: general call
    start_c(); wr_byte(8'h00, 0, a); chk("R7 general call ack", a, 1);
    wr_byte(8'h04, 0, a); chk("R7 non-reset second byte nack", a, 0);
    stop_c();
    pins = 5'h0A;
    start_c(); wr_byte(8'h8A, 0, a); chk("R7 pins not re-latched yet", a, 1); stop_c();
    start_c(); wr_byte(8'h94, 0, a); chk("R7 new pins ignored before reset", a, 0); stop_c();
    start_c(); wr_byte(8'h00, 0, a); wr_byte(8'h06, 0, a); chk("R7 reset byte ack", a, 1); stop_c();
    start_c(); wr_byte(8'h95, 0, a); chk("R7 new address after soft reset", a, 1);
    rd_byte(0, d); chk("R7 index cleared by soft reset", d, 8'h6B);
    stop_c();
    start_c(); wr_byte(8'h8A, 0, a); chk("R7 old address refused", a, 0); stop_c();

    repeat (20) @(negedge clk);
    chk("R4 all expected writes seen", exp_q.size(), 0);
    chk("R10 sda_oe stable while SCL high", oe_bad, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule